// File: doc/BRIEF.md
# Staged Interrupt Request Controller

This block gathers interrupt events from sixteen sources and turns them into one request line for a processor core. Software reaches it through a byte-wide register window. A 16-bit mask selects which sources may interrupt, and a 16-bit pending register records events. Software clears a pending bit by writing 1 to it. A single master-enable bit gates the whole request.

Every control value is held twice: a staging copy that bus writes and source pulses change, and an effective copy that loads from staging only on a qualified step (`step_en` high at a clock edge). On each step, a request register captures master-enable AND any (mask AND pending), taken from the effective copies before they reload. The request output is that register delayed by one more step. An enabling write therefore reaches the core after three steps.

The core pulses a sample strobe at the point between a pipeline flush and the next fetch. The block then registers the request it sees, together with a take decision that is suppressed while the core's interrupt-disable bit is set. The bus is a single-cycle register port with no handshake and no back-pressure: a write lands on the clock edge where `bus_we` is high, and read data is combinational from the address.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset, all staging and effective copies, the request register, `irq_out`, `irq_seen` and `irq_take` are 0, and every read returns 0.
- R2: A write to offset 0x200 or 0x201 replaces the low or high byte of the staging mask. A read of those offsets returns the effective mask byte, which takes the staging value at the next step.
- R3: A write to offset 0x208 stores only `bus_wdata` bit 0 into the staging master enable. A read of 0x208 returns the effective master enable in bit 0, with bits 7:1 reading 0.
- R4: Offset 0x209 and every unmapped offset read as 0, and writes to them change no state.
- R5: Writing to offset 0x202 or 0x203 clears each staging pending bit (low or high byte) whose data bit is 1 and leaves the others unchanged. Reads return the effective pending byte.
- R6: `src_set` bit i sets staging pending bit i in that cycle. When it meets a write-1 clear of the same bit in the same cycle, the set wins.
- R7: On each step, the request register loads effective-enable AND OR(effective mask AND effective pending), using values from before that step's reload, and `irq_out` loads the previous request value. With mask and master enable already effective, a pending event reaches `irq_out` on the third step.
- R8: Without a step, the effective copies, the request register and `irq_out` hold their values.
- R9: On a clock edge with `fetch_smp` high, `irq_seen` captures `irq_out` and `irq_take` captures `irq_out` AND NOT `core_idis`. Both hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Qualifies a step: effective copies and request stages advance |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| src_set | input | 16 | Per-source event pulses that set pending bits |
| irq_out | output | 1 | Delayed request line to the core |
| fetch_smp | input | 1 | Core sample strobe between flush and fetch |
| core_idis | input | 1 | Core interrupt-disable bit |
| irq_seen | output | 1 | Request value captured at the last sample |
| irq_take | output | 1 | Interrupt accepted at the last sample |

## Verification
The pending register can be hit in one cycle both by a source pulse and by a software write-1 clear of the same bit. Those two updates must merge with the set winning. The bench provokes this directly, with bit 2 pulsed and cleared together. The random phase also mixes sparse pulses with frequent writes to 0x202 and 0x203. A bench model, updated on every edge, judges each result through reads of the pending bytes and through the request line.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int ADDR_W = 12;
  localparam int NSRC_DEF = 16;
  localparam logic [ADDR_W-1:0] OFF_MASK = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_PEND = 12'h202;
  localparam logic [ADDR_W-1:0] OFF_ME = 12'h208;
  localparam logic [ADDR_W-1:0] OFF_ME_HI = 12'h209;
endpackage

// File: rtl/lirq_bank.sv
module lirq_bank #(
  parameter int W = 16,
  parameter bit W1C = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [W/8-1:0] wr_be,
  input  logic [7:0]     wr_byte,
  input  logic [W-1:0]   set_vec,
  output logic [W-1:0]   stg,
  output logic [W-1:0]   eff
);
  localparam int NB = W / 8;
  logic [W-1:0] stg_nx;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      if (W1C) begin : g_clr
        assign stg_nx[8*b +: 8] = (stg[8*b +: 8] & ~(wr_be[b] ? wr_byte : 8'h00))
                                  | set_vec[8*b +: 8];
      end else begin : g_ovr
        assign stg_nx[8*b +: 8] = (wr_be[b] ? wr_byte : stg[8*b +: 8])
                                  | set_vec[8*b +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      eff <= '0;
    end else begin
      stg <= stg_nx;
      if (step) eff <= stg;
    end
  end

  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (eff == $past(stg)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(eff));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stg & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/lirq_regfile.sv
module lirq_regfile
  import lirq_pkg::*;
#(
  parameter int NSRC = NSRC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NSRC-1:0]   src_set,
  output logic              me_eff,
  output logic [NSRC-1:0]   mask_eff,
  output logic [NSRC-1:0]   pend_eff
);
  localparam int NB = NSRC / 8;

  logic [NB-1:0]   mask_hit, pend_hit;
  logic [NSRC-1:0] mask_stg, pend_stg;
  logic            me_stg;
  logic            me_hit;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_dec
      assign mask_hit[b] = (bus_addr == OFF_MASK + ADDR_W'(b));
      assign pend_hit[b] = (bus_addr == OFF_PEND + ADDR_W'(b));
    end
  endgenerate
  assign me_hit = (bus_addr == OFF_ME);

  lirq_bank #(.W(NSRC), .W1C(1'b0)) u_mask (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wr_be({NB{bus_we}} & mask_hit), .wr_byte(bus_wdata),
    .set_vec('0), .stg(mask_stg), .eff(mask_eff)
  );

  lirq_bank #(.W(NSRC), .W1C(1'b1)) u_pend (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wr_be({NB{bus_we}} & pend_hit), .wr_byte(bus_wdata),
    .set_vec(src_set), .stg(pend_stg), .eff(pend_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_stg <= 1'b0;
      me_eff <= 1'b0;
    end else begin
      if (bus_we && me_hit) me_stg <= bus_wdata[0];
      if (step) me_eff <= me_stg;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int k = 0; k < NB; k++) begin
      if (mask_hit[k]) bus_rdata = mask_eff[8*k +: 8];
      if (pend_hit[k]) bus_rdata = pend_eff[8*k +: 8];
    end
    if (me_hit) bus_rdata = {7'b0, me_eff};
  end

  p_me_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (me_eff == $past(me_stg)));
  p_me_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    me_hit |-> (bus_rdata[7:1] == 7'b0));
  p_hi_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_ME_HI && src_set == '0)
      |=> ($stable(me_stg) && $stable(mask_stg) && $stable(pend_stg)));
endmodule

// File: rtl/lirq_req.sv
module lirq_req #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            me_eff,
  input  logic [NSRC-1:0] mask_eff,
  input  logic [NSRC-1:0] pend_eff,
  output logic            irq_out
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      irq_out <= 1'b0;
    end else if (step) begin
      req_q   <= me_eff & |(mask_eff & pend_eff);
      irq_out <= req_q;
    end
  end

  p_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (irq_out == $past(req_q)));
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !me_eff) |=> !req_q);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(req_q) && $stable(irq_out)));
endmodule

// File: rtl/lirq_sample.sv
module lirq_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_smp,
  input  logic irq_out,
  input  logic core_idis,
  output logic irq_seen,
  output logic irq_take
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_seen <= 1'b0;
      irq_take <= 1'b0;
    end else if (fetch_smp) begin
      irq_seen <= irq_out;
      irq_take <= irq_out & ~core_idis;
    end
  end

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_smp |=> (irq_seen == $past(irq_out)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_smp |=> ($stable(irq_seen) && $stable(irq_take)));
  p_take_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_seen);
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int NSRC = NSRC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NSRC-1:0]   src_set,
  output logic              irq_out,
  input  logic              fetch_smp,
  input  logic              core_idis,
  output logic              irq_seen,
  output logic              irq_take
);
  logic            me_eff;
  logic [NSRC-1:0] mask_eff, pend_eff;

  lirq_regfile #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .step(step_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_set(src_set),
    .me_eff(me_eff), .mask_eff(mask_eff), .pend_eff(pend_eff)
  );

  lirq_req #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .step(step_en),
    .me_eff(me_eff), .mask_eff(mask_eff), .pend_eff(pend_eff),
    .irq_out(irq_out)
  );

  lirq_sample u_smp (
    .clk(clk), .rst_n(rst_n), .fetch_smp(fetch_smp),
    .irq_out(irq_out), .core_idis(core_idis),
    .irq_seen(irq_seen), .irq_take(irq_take)
  );

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_out && !irq_seen && !irq_take));
endmodule

// File: tb/sim_lirq_ctrl.sv
`timescale 1ns/1ps
module sim_lirq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, step_en = 1'b0, bus_we = 1'b0;
  logic fetch_smp = 1'b0, core_idis = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] src_set = '0;
  logic [7:0]  bus_rdata;
  logic irq_out, irq_seen, irq_take;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_set(src_set), .irq_out(irq_out), .fetch_smp(fetch_smp),
    .core_idis(core_idis), .irq_seen(irq_seen), .irq_take(irq_take)
  );

  // reference model built from the requirements
  logic        m_me_s = 0, m_me_e = 0, m_req = 0, m_out = 0, m_seen = 0, m_take = 0;
  logic [15:0] m_en_s = 0, m_en_e = 0, m_fl_s = 0, m_fl_e = 0, m_clr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_me_s = 0; m_me_e = 0; m_req = 0; m_out = 0; m_seen = 0; m_take = 0;
      m_en_s = 0; m_en_e = 0; m_fl_s = 0; m_fl_e = 0;
    end else begin
      if (fetch_smp) begin
        m_seen = m_out;
        m_take = m_out & ~core_idis;
      end
      if (step_en) begin
        m_out = m_req;
        m_req = m_me_e & |(m_en_e & m_fl_e);
        m_me_e = m_me_s; m_en_e = m_en_s; m_fl_e = m_fl_s;
      end
      m_clr = '0;
      if (bus_we) begin
        case (bus_addr)
          12'h200: m_en_s[7:0]  = bus_wdata;
          12'h201: m_en_s[15:8] = bus_wdata;
          12'h202: m_clr[7:0]   = bus_wdata;
          12'h203: m_clr[15:8]  = bus_wdata;
          12'h208: m_me_s       = bus_wdata[0];
          default: ;
        endcase
      end
      m_fl_s = (m_fl_s & ~m_clr) | src_set;
    end
  end

  function automatic logic [7:0] model_read(input logic [11:0] a);
    case (a)
      12'h200: return m_en_e[7:0];
      12'h201: return m_en_e[15:8];
      12'h202: return m_fl_e[7:0];
      12'h203: return m_fl_e[15:8];
      12'h208: return {7'b0, m_me_e};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h200, 12'h201: return "R2 mask read";
      12'h202, 12'h203: return "R5 pending read";
      12'h208:          return "R3 enable read";
      default:          return "R4 empty read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    chk("R7 irq_out", {31'b0, irq_out}, {31'b0, m_out});
    chk("R9 irq_seen", {31'b0, irq_seen}, {31'b0, m_seen});
    chk("R9 irq_take", {31'b0, irq_take}, {31'b0, m_take});
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] lit, input bit use_lit, input string tag);
    bus_we = 1'b0;
    bus_addr = a;
    #1;
    chk(tag, {24'b0, bus_rdata}, {24'b0, use_lit ? lit : model_read(a)});
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic step1();
    step_en = 1'b1;
    tick();
    step_en = 1'b0;
  endtask

  localparam logic [11:0] ADDRS [8] = '{12'h200, 12'h201, 12'h202, 12'h203,
                                        12'h208, 12'h209, 12'h20A, 12'h000};

  initial begin
    int n;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2024);
    tick(); tick();
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    chk("R1 irq_take", {31'b0, irq_take}, 0);
    foreach (ADDRS[i]) rd(ADDRS[i], 8'h00, 1'b1, "R1 reset read");

    // R3: only bit 0 stored, visible after a step
    wr(12'h208, 8'hFE);
    step1();
    rd(12'h208, 8'h00, 1'b1, "R3 bit0 only");
    wr(12'h208, 8'hFF);
    rd(12'h208, 8'h00, 1'b1, "R3 staged not yet effective");
    step1();
    rd(12'h208, 8'h01, 1'b1, "R3 effective after step");

    // R2: mask staging
    wr(12'h200, 8'h05);
    rd(12'h200, 8'h00, 1'b1, "R2 staged not yet effective");
    step1();
    rd(12'h200, 8'h05, 1'b1, "R2 effective after step");

    // R4: high enable byte and unmapped writes ignored
    wr(12'h209, 8'hFF);
    wr(12'h20A, 8'hFF);
    step1();
    rd(12'h209, 8'h00, 1'b1, "R4 0x209 reads zero");
    rd(12'h208, 8'h01, 1'b1, "R4 enable unchanged");
    rd(12'h201, 8'h00, 1'b1, "R4 mask unchanged");

    // R7: three-step latency from a pending event
    src_set = 16'h0001;
    tick();
    src_set = '0;
    n = 0;
    for (int s = 0; s < 6; s++) begin
      if (irq_out) break;
      step1();
      n++;
    end
    chk("R7 steps to irq_out", n, 3);

    // R8: no step keeps everything, even after a clear
    wr(12'h202, 8'h01);
    for (int s = 0; s < 4; s++) tick();
    chk("R8 irq_out held", {31'b0, irq_out}, 1);
    rd(12'h202, 8'h01, 1'b1, "R8 effective pending held");
    for (int s = 0; s < 3; s++) step1();
    chk("R5 cleared request drops", {31'b0, irq_out}, 0);
    rd(12'h202, 8'h00, 1'b1, "R5 pending cleared");

    // R6: set and clear of bit 2 in one cycle
    src_set = 16'h0004;
    wr(12'h202, 8'h04);
    src_set = '0;
    step1();
    rd(12'h202, 8'h04, 1'b1, "R6 set wins over clear");

    // R9: sampling with and without interrupt-disable
    step1(); step1();
    chk("R7 request from bit 2", {31'b0, irq_out}, 1);
    fetch_smp = 1'b1; core_idis = 1'b1;
    tick();
    chk("R9 seen while disabled", {31'b0, irq_seen}, 1);
    chk("R9 no take while disabled", {31'b0, irq_take}, 0);
    core_idis = 1'b0;
    tick();
    chk("R9 take when enabled", {31'b0, irq_take}, 1);
    fetch_smp = 1'b0;

    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      step_en   = ($urandom % 4) != 0;
      fetch_smp = ($urandom % 3) == 0;
      core_idis = $urandom % 2;
      src_set   = (($urandom % 6) == 0) ? 16'($urandom) : 16'h0;
      bus_we    = ($urandom % 3) == 0;
      bus_addr  = ADDRS[$urandom % 8];
      bus_wdata = 8'($urandom);
      tick();
      begin
        logic [11:0] ra;
        ra = ADDRS[$urandom % 8];
        rd(ra, 8'h00, 1'b0, tag_of(ra));
      end
    end
    step_en = 1'b0; fetch_smp = 1'b0; src_set = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule